// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Start

This block produces the count-enable strobes for two timer/counters. Both timers share one free-running divider clocked by the I/O clock. Each timer has a 3-bit source selector. The selector picks one of five divided rates, stops the timer, or follows the timer's own external pin on a chosen edge. A pin source does not pass through the divider. The pin goes through a two-flop synchronizer and an edge-detect register, and each detected edge gives one strobe cycle. Because the detector samples with the I/O clock, pin edges must stay well below half the I/O clock rate. A limit of about the I/O clock divided by 2.5 is the safe figure.

An 8-bit control register drives the divider reset. The register holds three bits: a synchronization-mode bit, a reset bit for this divider, and a reset bit for a second divider that lives outside this block. The second bit is only stored and driven out as a held reset. Outside synchronization mode, a reset bit that software sets clears itself one cycle later. Inside synchronization mode, the reset bits keep whatever value was written, so the timers stay frozen while software configures them. Writing the mode bit back to zero clears both reset bits in the same cycle, and every held timer starts again on the same edge.

Top module: `tmr_presc_share`

## Requirements
- R1: After reset, reg_rdata is 0x00, hold_aux is 0, and with both selectors at 0 both strobes are 0.
- R2: A write stores data bit 7 as the sync-mode bit, bit 1 as the auxiliary reset and bit 0 as the shared divider reset. Reads return these bits in the same positions, and bits 6 to 2 always read as 0.
- R3: With sync mode at 0, a written shared-reset bit of 1 reads as 1 for exactly one cycle and then reads as 0 without any further write.
- R4: With sync mode at 1, both reset bits keep their written values. While the shared reset is 1, strobes from selector codes 1 to 5 stay 0. hold_aux follows the auxiliary reset bit.
- R5: Writing 0x00 while sync mode is 1 clears all three bits on the next edge, and the divider then restarts from zero for both timers at once.
- R6: Selector codes 1, 2, 3, 4 and 5 divide by 1, 8, 64, 256 and 1024. Number the cycles after the divider leaves reset from j=0. The strobe is 1 exactly in the cycles where j mod N equals N-1.
- R7: Selector code 0 keeps the timer's strobe at 0.
- R8: Code 7 strobes on a rising pin edge and code 6 on a falling pin edge. A pin change that is set up before clock edge e gives a strobe of exactly one cycle, starting after edge e+1. The opposite edge gives no strobe.
- R9: A held shared reset does not block strobes from codes 6 and 7.
- R10: Both timers see the same divider. Two timers on different divided codes keep their phases relative to the same restart cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| cs_a | input | 3 | Source selector for timer A |
| cs_b | input | 3 | Source selector for timer B |
| ext_a | input | 1 | External clock pin for timer A |
| ext_b | input | 1 | External clock pin for timer B |
| tick_a | output | 1 | Count-enable strobe for timer A |
| tick_b | output | 1 | Count-enable strobe for timer B |
| hold_aux | output | 1 | Held reset for the second divider |

## Verification
Two functions can act in the same cycle: a pin edge can reach the edge detector while the shared divider reset is held in sync mode. The bench sets the hold, raises timer B's pin with code 7, and expects the strobe in the usual cycle, while timer A on a divided code stays at 0. The release path is also tested in every configuration of a sweep. Each selector code is paired with a different code on the other timer, and after the sync-mode bit clears, every cycle up to twice the longer period is compared with the arithmetic phase j mod N.

// File: rtl/tmr_presc_share.sv
module tmr_presc_share #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [2:0] cs_a,
  input  logic [2:0] cs_b,
  input  logic       ext_a,
  input  logic       ext_b,
  output logic       tick_a,
  output logic       tick_b,
  output logic       hold_aux
);
  localparam logic [7:0] WMASK = 8'h83;

  logic [7:0]       ctl;
  logic [DIV_W-1:0] cnt;
  logic             hold_main;
  logic [5:0]       pre;

  assign hold_main = ctl[0];
  assign hold_aux  = ctl[1];
  assign reg_rdata = ctl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (reg_we) ctl <= reg_wdata & WMASK;
    else             ctl <= {ctl[7], 5'b0, ctl[1:0] & {2{ctl[7]}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt <= '0;
    else if (hold_main) cnt <= '0;
    else                cnt <= cnt + 1'b1;

  assign pre[0] = 1'b0;
  assign pre[1] = !hold_main;
  assign pre[2] = !hold_main && (&cnt[2:0]);
  assign pre[3] = !hold_main && (&cnt[5:0]);
  assign pre[4] = !hold_main && (&cnt[7:0]);
  assign pre[5] = !hold_main && (&cnt[9:0]);

  logic [1:0] pin;
  logic [2:0] sel [2];
  logic [1:0] tick;
  assign pin    = {ext_b, ext_a};
  assign sel[0] = cs_a;
  assign sel[1] = cs_b;

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    logic [2:0] sy;
    logic       rise, fall;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sy <= '0;
      else        sy <= {sy[1:0], pin[t]};
    assign rise = sy[1] && !sy[2];
    assign fall = !sy[1] && sy[2];
    always_comb
      case (sel[t])
        3'd6:    tick[t] = fall;
        3'd7:    tick[t] = rise;
        default: tick[t] = pre[sel[t]];
      endcase
  end

  assign tick_a = tick[0];
  assign tick_b = tick[1];
endmodule

// File: rtl/tmr_presc_share_chk.sv
module tmr_presc_share_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [2:0] cs_a,
  input logic [2:0] cs_b,
  input logic       tick_a,
  input logic       tick_b,
  input logic       hold_aux
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:2] == 5'b0);

  assert_aux_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_aux == reg_rdata[1]);

  assert_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[7] && reg_rdata[0] && !reg_we) |=> !reg_rdata[0]);

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && !reg_we) |=> (reg_rdata[1:0] == $past(reg_rdata[1:0])));

  assert_frozen_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && cs_a != 3'd0 && cs_a < 3'd6) |-> !tick_a);

  assert_frozen_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && cs_b != 3'd0 && cs_b < 3'd6) |-> !tick_b);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && reg_we && reg_wdata == 8'h00) |=> reg_rdata == 8'h00);

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a == 3'd0) |-> !tick_a);

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && cs_a[2:1] == 2'b11) |=> !(tick_a && cs_a == $past(cs_a)));
endmodule

bind tmr_presc_share tmr_presc_share_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .cs_a(cs_a), .cs_b(cs_b), .tick_a(tick_a),
  .tick_b(tick_b), .hold_aux(hold_aux)
);

// File: tb/test_tmr_presc_share.sv
module test_tmr_presc_share;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] cs_a = '0, cs_b = '0;
  logic       ext_a = 1'b0, ext_b = 1'b0;
  logic       tick_a, tick_b, hold_aux;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_presc_share i_tmr_presc_share (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  function automatic int div_of(input int code);
    case (code)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      default: return 1024;
    endcase
  endfunction

  task automatic pin_edge(input bit which_b, input logic val, input bit exp_tick, input string tag);
    if (which_b) ext_b = val; else ext_a = val;
    step();
    chk((which_b ? tick_b : tick_a) == 1'b0, tag, which_b ? tick_b : tick_a, 0);
    step();
    chk((which_b ? tick_b : tick_a) == exp_tick, tag, which_b ? tick_b : tick_a, exp_tick);
    step();
    chk((which_b ? tick_b : tick_a) == 1'b0, tag, which_b ? tick_b : tick_a, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1
    chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    chk(hold_aux == 1'b0, "R1 hold_aux", hold_aux, 0);
    chk(!tick_a && !tick_b, "R1 ticks", {tick_a, tick_b}, 0);

    // R2, R4: all ones written in sync mode
    wr(8'hFF);
    chk(reg_rdata == 8'h83, "R2 layout", reg_rdata, 8'h83);
    chk(hold_aux == 1'b1, "R4 hold_aux", hold_aux, 1);
    cs_a = 3'd1; cs_b = 3'd2;
    for (int i = 0; i < 20; i++) begin
      step();
      chk(!tick_a && !tick_b, "R4 frozen", {tick_a, tick_b}, 0);
      chk(reg_rdata == 8'h83, "R4 kept", reg_rdata, 8'h83);
    end
    wr(8'h82);
    chk(reg_rdata == 8'h82, "R2 aux only", reg_rdata, 8'h82);
    wr(8'h00);
    chk(reg_rdata == 8'h00, "R5 release", reg_rdata, 0);
    chk(hold_aux == 1'b0, "R5 aux released", hold_aux, 0);

    // R6, R10, R5: sweep of divided codes after synchronized release
    for (int ca = 1; ca <= 5; ca++) begin
      int cb, na, nb, len;
      cb = (ca % 5) + 1;
      na = div_of(ca); nb = div_of(cb);
      cs_a = 3'(ca); cs_b = 3'(cb);
      wr(8'h81);
      step(); step();
      chk(!tick_a && !tick_b, "R4 held sweep", {tick_a, tick_b}, 0);
      wr(8'h00);
      chk(reg_rdata == 8'h00, "R5 bits cleared", reg_rdata, 0);
      len = 2 * ((na > nb) ? na : nb);
      for (int j = 0; j < len; j++) begin
        chk(tick_a == ((j % na) == na - 1), "R6 timer A", tick_a, (j % na) == na - 1);
        chk(tick_b == ((j % nb) == nb - 1), "R10 timer B", tick_b, (j % nb) == nb - 1);
        step();
      end
    end

    // R3: self-clearing outside sync mode
    cs_a = 3'd2;
    wr(8'h01);
    chk(reg_rdata == 8'h01, "R3 set", reg_rdata, 1);
    chk(tick_a == 1'b0, "R3 tick during reset", tick_a, 0);
    step();
    chk(reg_rdata == 8'h00, "R3 cleared", reg_rdata, 0);
    for (int j = 0; j < 16; j++) begin
      chk(tick_a == ((j % 8) == 7), "R3 restart phase", tick_a, (j % 8) == 7);
      step();
    end

    // R7
    cs_a = 3'd0;
    for (int i = 0; i < 40; i++) begin
      chk(tick_a == 1'b0, "R7 stopped", tick_a, 0);
      step();
    end

    // R8
    cs_a = 3'd7;
    step(); step(); step();
    pin_edge(1'b0, 1'b1, 1'b1, "R8 rise on code 7");
    pin_edge(1'b0, 1'b0, 1'b0, "R8 fall on code 7");
    cs_a = 3'd6;
    pin_edge(1'b0, 1'b1, 1'b0, "R8 rise on code 6");
    pin_edge(1'b0, 1'b0, 1'b1, "R8 fall on code 6");

    // R9: pin edge while shared reset held
    cs_a = 3'd1; cs_b = 3'd7;
    wr(8'h81);
    pin_edge(1'b1, 1'b1, 1'b1, "R9 pin during hold");
    chk(tick_a == 1'b0, "R9 divided still frozen", tick_a, 0);
    chk(reg_rdata == 8'h81, "R9 hold kept", reg_rdata, 8'h81);
    wr(8'h00);
    chk(tick_a == 1'b1, "R5 resume div1", tick_a, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule